// File: doc/BRIEF.md
# Dual-Count Tagged Conditional Branch Predictor

This block predicts the direction of conditional branches. It uses a table of 2-bit counters indexed by the pc. Above that table sit two tagged tables. Each tagged table is indexed by a hash of the pc with a different length of global branch history: 8 bits for the short table and 32 bits for the long one. A tagged entry does not keep an up/down counter. It keeps two small counts, one of taken outcomes and one of not-taken outcomes. A tagged entry speaks only when those counts show strong evidence. Otherwise the prediction falls back to the shorter table or to the base table.

The predict port is purely combinational. A pc goes in, and the direction, a confidence flag and the identity of the supplying table come out in the same cycle. The update port takes a resolved branch: its pc, its outcome and whether it was mispredicted. The update is applied at the next clock edge. Global history shifts only at resolve, so the caller must predict and resolve branches in order. On a mispredict a new tagged entry may be allocated. An adaptive throttle counter decides whether that allocation is allowed. The throttle counter rises when fresh entries turn out to be wrong on their first reuse.

Top module: `bayes_tage`

## Requirements
- R1: After reset, every tagged entry is invalid, every base counter is 01, history is zero and the throttle is zero. As a result every pc predicts not-taken, with pred_conf=0 and pred_src=0.
- R2: Let F(len) be the XOR, bit by bit, of the 8-bit chunks of the low len history bits. Here history bit 0 is the most recent outcome. A table of history length len is read at index pc[9:2]^F(len). Its tag is pc[17:10]^{F(len)[6:0],F(len)[7]}. The base table is read at index pc[11:2].
- R3: Base counters are 2-bit saturating counters. Every update moves the counter toward the outcome. When the base table supplies the prediction, the direction is the counter's MSB.
- R4: On each update, every hitting tagged entry changes its 3-bit counts. The count that matches the outcome increments. If that count is already 7, the opposite count decrements instead, unless the opposite count is already 0.
- R5: A tagged entry predicts taken when taken count > not-taken count. It is confident when the smaller count is 0 and the larger count is at least 2.
- R6: The provider is chosen in this order: the long table if it hits and is confident, then the short table if it hits and is confident, then the base table. The provider is reported on pred_src as 2, 1 or 0. pred_conf is 1 exactly when a tagged table supplies the prediction.
- R7: Consider an update that is a mispredict, where the long table did not hit and the throttle is below 128. This update allocates one entry in the table just above the longest hitting table: the short table if neither table hits, otherwise the long table. The new entry holds count 1 for the observed outcome, 0 for the other, and is marked fresh.
- R8: The first hit on a fresh entry scores that entry and clears the fresh mark. If the entry's direction was wrong, the throttle rises by 16. If it was right, the throttle falls by 1. A denied allocation lowers the throttle by 1. The throttle saturates at 0 and 255.
- R9: Each update shifts its outcome into the history. History is unchanged in cycles without an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | pc of the branch to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_conf | output | 1 | High confidence, meaning a tagged entry supplies the prediction |
| pred_src | output | 2 | Providing table: 0 base, 1 short history, 2 long history |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | pc of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_mispredict | input | 1 | The earlier prediction for this branch was wrong |

## Verification
The bench goes after the following corner cases:

- **Saturation edge of the dual counts.** A long taken run followed by a flip exercises it. A design that keeps incrementing past 7, or that fails to lower the opposite count, drifts from the expected direction and confidence.
- **The first observations of a fresh entry.** An entry with counts of 1 must not be treated as confident. A design that is too eager shows a tagged pred_src one update too early.
- **The throttle under random outcomes.** Random outcomes drive the throttle past its threshold, and the bench requires that allocations are then refused. A design that ignores the throttle, or mis-scores fresh entries, allocates entries that change later providers.
- **History and hash alignment.** Periodic patterns on several pcs test it. A shifted history or a wrong fold lands in other entries and gives predictions that differ from the bench's model.

// File: rtl/bayes_tage.sv
module bayes_tage #(
  parameter int PC_W      = 32,
  parameter int BASE_IW   = 10,
  parameter int TAB_IW    = 8,
  parameter int TAG_W     = 8,
  parameter int HIST_S    = 8,
  parameter int HIST_L    = 32,
  parameter int CNT_W     = 3,
  parameter int THR_W     = 8,
  parameter int THR_LIMIT = 128,
  parameter int THR_UP    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_conf,
  output logic [1:0]      pred_src,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_mispredict
);

  localparam int BASE_N  = 1 << BASE_IW;
  localparam int TAB_N   = 1 << TAB_IW;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int THR_MAX = (1 << THR_W) - 1;

  logic [HIST_L-1:0] ghist;
  logic [THR_W-1:0]  thr;
  logic [1:0]        base_q  [BASE_N];
  logic              vld_q   [2][TAB_N];
  logic              fresh_q [2][TAB_N];
  logic [TAG_W-1:0]  tag_q   [2][TAB_N];
  logic [CNT_W-1:0]  ct_q    [2][TAB_N];
  logic [CNT_W-1:0]  cn_q    [2][TAB_N];

  function automatic int hlen(input int k);
    return (k == 0) ? HIST_S : HIST_L;
  endfunction

  function automatic logic [TAB_IW-1:0] fold_i(input logic [HIST_L-1:0] h, input int len);
    logic [TAB_IW-1:0] f;
    f = '0;
    for (int i = 0; i < HIST_L / TAB_IW; i++)
      if (i * TAB_IW < len) f = f ^ h[i*TAB_IW +: TAB_IW];
    return f;
  endfunction

  function automatic logic [TAG_W-1:0] fold_t(input logic [HIST_L-1:0] h, input int len);
    logic [TAG_W-1:0] f;
    f = '0;
    for (int i = 0; i < HIST_L / TAG_W; i++)
      if (i * TAG_W < len) f = f ^ h[i*TAG_W +: TAG_W];
    return f;
  endfunction

  function automatic logic [TAB_IW-1:0] hidx(input logic [PC_W-1:0] pc, input logic [HIST_L-1:0] h, input int len);
    return pc[TAB_IW+1:2] ^ fold_i(h, len);
  endfunction

  function automatic logic [TAG_W-1:0] htag(input logic [PC_W-1:0] pc, input logic [HIST_L-1:0] h, input int len);
    logic [TAG_W-1:0] f;
    f = fold_t(h, len);
    return pc[TAG_W+TAB_IW+1:TAB_IW+2] ^ {f[TAG_W-2:0], f[TAG_W-1]};
  endfunction

  function automatic logic hi_conf(input logic [CNT_W-1:0] t, input logic [CNT_W-1:0] n);
    return ((t == '0) && (n >= CNT_W'(2))) || ((n == '0) && (t >= CNT_W'(2)));
  endfunction

  logic [TAB_IW-1:0] p_i [2];
  logic [TAB_IW-1:0] u_i [2];
  logic p_cf [2], p_dir [2];
  logic u_hit [2], u_dir [2], u_fr [2];

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      p_i[k]   = hidx(pred_pc, ghist, hlen(k));
      p_cf[k]  = vld_q[k][p_i[k]] && (tag_q[k][p_i[k]] == htag(pred_pc, ghist, hlen(k)))
                 && hi_conf(ct_q[k][p_i[k]], cn_q[k][p_i[k]]);
      p_dir[k] = ct_q[k][p_i[k]] > cn_q[k][p_i[k]];
      u_i[k]   = hidx(upd_pc, ghist, hlen(k));
      u_hit[k] = vld_q[k][u_i[k]] && (tag_q[k][u_i[k]] == htag(upd_pc, ghist, hlen(k)));
      u_dir[k] = ct_q[k][u_i[k]] > cn_q[k][u_i[k]];
      u_fr[k]  = fresh_q[k][u_i[k]];
    end
  end

  wire [BASE_IW-1:0] p_bi = pred_pc[BASE_IW+1:2];
  wire [BASE_IW-1:0] u_bi = upd_pc[BASE_IW+1:2];

  assign pred_src   = p_cf[1] ? 2'd2 : (p_cf[0] ? 2'd1 : 2'd0);
  assign pred_taken = p_cf[1] ? p_dir[1] : (p_cf[0] ? p_dir[0] : base_q[p_bi][1]);
  assign pred_conf  = p_cf[1] | p_cf[0];

  wire       alloc_want = upd_valid && upd_mispredict && !u_hit[1];
  wire       alloc_ok   = alloc_want && (int'(thr) < THR_LIMIT);
  wire       alloc_k    = u_hit[0];
  logic [THR_W-1:0] thr_nx;

  always_comb begin
    int s;
    s = int'(thr);
    for (int k = 0; k < 2; k++)
      if (upd_valid && u_hit[k] && u_fr[k]) s = (u_dir[k] == upd_taken) ? s - 1 : s + THR_UP;
    if (alloc_want && !alloc_ok) s = s - 1;
    if (s < 0) thr_nx = '0;
    else if (s > THR_MAX) thr_nx = THR_W'(THR_MAX);
    else thr_nx = THR_W'(s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      thr   <= '0;
      for (int i = 0; i < BASE_N; i++) base_q[i] <= 2'b01;
      for (int k = 0; k < 2; k++)
        for (int i = 0; i < TAB_N; i++) begin
          vld_q[k][i]   <= 1'b0;
          fresh_q[k][i] <= 1'b0;
          tag_q[k][i]   <= '0;
          ct_q[k][i]    <= '0;
          cn_q[k][i]    <= '0;
        end
    end else if (upd_valid) begin
      ghist <= {ghist[HIST_L-2:0], upd_taken};
      thr   <= thr_nx;
      if (upd_taken && base_q[u_bi] != 2'b11) base_q[u_bi] <= base_q[u_bi] + 2'd1;
      if (!upd_taken && base_q[u_bi] != 2'b00) base_q[u_bi] <= base_q[u_bi] - 2'd1;
      for (int k = 0; k < 2; k++)
        if (u_hit[k]) begin
          fresh_q[k][u_i[k]] <= 1'b0;
          if (upd_taken) begin
            if (int'(ct_q[k][u_i[k]]) < CNT_MAX) ct_q[k][u_i[k]] <= ct_q[k][u_i[k]] + 1'b1;
            else if (cn_q[k][u_i[k]] != '0) cn_q[k][u_i[k]] <= cn_q[k][u_i[k]] - 1'b1;
          end else begin
            if (int'(cn_q[k][u_i[k]]) < CNT_MAX) cn_q[k][u_i[k]] <= cn_q[k][u_i[k]] + 1'b1;
            else if (ct_q[k][u_i[k]] != '0) ct_q[k][u_i[k]] <= ct_q[k][u_i[k]] - 1'b1;
          end
        end
      if (alloc_ok) begin
        vld_q[alloc_k][u_i[alloc_k]]   <= 1'b1;
        fresh_q[alloc_k][u_i[alloc_k]] <= 1'b1;
        tag_q[alloc_k][u_i[alloc_k]]   <= htag(upd_pc, ghist, hlen(int'(alloc_k)));
        ct_q[alloc_k][u_i[alloc_k]]    <= upd_taken ? CNT_W'(1) : '0;
        cn_q[alloc_k][u_i[alloc_k]]    <= upd_taken ? '0 : CNT_W'(1);
      end
    end
  end

  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));
  a_r8_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(thr));
  a_r6_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pred_src != 2'd3);
  a_r6_conf_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    pred_conf == (pred_src != 2'd0));

endmodule

// File: tb/bayes_tage_bench.sv
module bayes_tage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, upd_mispredict = 1'b0;
  logic pred_taken, pred_conf;
  logic [1:0] pred_src;

  bayes_tage u_bayes_tage (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_conf(pred_conf), .pred_src(pred_src), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_mispredict(upd_mispredict));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int m_b [1024];
  bit m_v [2][256], m_f [2][256];
  int m_tg [2][256], m_t [2][256], m_n [2][256];
  logic [31:0] m_h;
  int m_thr, m_denied, m_alloc, m_thr_peak;
  int mp_taken, mp_src, mp_conf;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mlen(int k);
    return k == 0 ? 8 : 32;
  endfunction

  function automatic logic [7:0] mfold(logic [31:0] h, int len);
    logic [7:0] r = '0;
    for (int j = 0; j < len; j++) r[j % 8] = r[j % 8] ^ h[j];
    return r;
  endfunction

  function automatic int midx(logic [31:0] pc, int len);
    return int'(pc[9:2] ^ mfold(m_h, len));
  endfunction

  function automatic int mtag(logic [31:0] pc, int len);
    logic [7:0] f = mfold(m_h, len);
    return int'(pc[17:10] ^ {f[6:0], f[7]});
  endfunction

  function automatic bit mconf(int t, int n);
    int lo = t < n ? t : n;
    int hi = t < n ? n : t;
    return lo == 0 && hi >= 2;
  endfunction

  function automatic void mpredict(logic [31:0] pc);
    mp_src = 0;
    mp_taken = m_b[pc[11:2]] >= 2;
    for (int k = 0; k < 2; k++) begin
      int i = midx(pc, mlen(k));
      if (m_v[k][i] && m_tg[k][i] == mtag(pc, mlen(k)) && mconf(m_t[k][i], m_n[k][i])) begin
        mp_src = k + 1;
        mp_taken = m_t[k][i] > m_n[k][i];
      end
    end
    mp_conf = mp_src != 0;
  endfunction

  function automatic void mupdate(logic [31:0] pc, bit tk, bit mis);
    int idx [2];
    bit hit [2];
    int s, a;
    bit want;
    for (int k = 0; k < 2; k++) begin
      idx[k] = midx(pc, mlen(k));
      hit[k] = m_v[k][idx[k]] && m_tg[k][idx[k]] == mtag(pc, mlen(k));
    end
    s = m_thr;
    for (int k = 0; k < 2; k++)
      if (hit[k] && m_f[k][idx[k]])
        s += ((m_t[k][idx[k]] > m_n[k][idx[k]]) == tk) ? -1 : 16;
    want = mis && !hit[1];
    a = hit[0] ? 1 : 0;
    if (want && m_thr >= 128) begin s -= 1; m_denied++; end
    for (int k = 0; k < 2; k++)
      if (hit[k]) begin
        int i = idx[k];
        m_f[k][i] = 0;
        if (tk) begin
          if (m_t[k][i] < 7) m_t[k][i]++; else if (m_n[k][i] > 0) m_n[k][i]--;
        end else begin
          if (m_n[k][i] < 7) m_n[k][i]++; else if (m_t[k][i] > 0) m_t[k][i]--;
        end
      end
    if (want && m_thr < 128) begin
      m_v[a][idx[a]] = 1; m_f[a][idx[a]] = 1;
      m_tg[a][idx[a]] = mtag(pc, mlen(a));
      m_t[a][idx[a]] = tk ? 1 : 0; m_n[a][idx[a]] = tk ? 0 : 1;
      m_alloc++;
    end
    if (tk && m_b[pc[11:2]] < 3) m_b[pc[11:2]]++;
    if (!tk && m_b[pc[11:2]] > 0) m_b[pc[11:2]]--;
    m_thr = s < 0 ? 0 : (s > 255 ? 255 : s);
    if (m_thr > m_thr_peak) m_thr_peak = m_thr;
    m_h = {m_h[30:0], tk};
  endfunction

  task automatic step(input logic [31:0] pc, input bit tk, input string req);
    @(negedge clk);
    upd_valid = 1'b0;
    pred_pc = pc;
    #1;
    mpredict(pc);
    chk(pred_taken == mp_taken[0], mp_src == 0 ? "R3" : "R5", {req, " direction"}, pred_taken, mp_taken);
    chk(pred_src == 2'(mp_src), "R6", {req, " source"}, pred_src, mp_src);
    chk(pred_conf == mp_conf[0], "R6", {req, " confidence"}, pred_conf, mp_conf);
    upd_valid = 1'b1;
    upd_pc = pc;
    upd_taken = tk;
    upd_mispredict = (mp_taken[0] != tk);
    @(posedge clk);
    mupdate(pc, tk, mp_taken[0] != tk);
  endtask

  initial begin
    logic [31:0] pcs [8];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) m_b[i] = 1;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 256; i++) begin
        m_v[k][i] = 0; m_f[k][i] = 0; m_tg[k][i] = 0; m_t[k][i] = 0; m_n[k][i] = 0;
      end
    m_h = '0; m_thr = 0; m_denied = 0; m_alloc = 0; m_thr_peak = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pred_pc = $urandom;
      #1;
      chk(pred_taken == 1'b0, "R1", "reset direction", pred_taken, 0);
      chk(pred_src == 2'd0, "R1", "reset source", pred_src, 0);
      chk(pred_conf == 1'b0, "R1", "reset confidence", pred_conf, 0);
    end
    for (int i = 0; i < 80; i++) step(32'h0000_1000, 1'b1, "R4 taken run");
    for (int i = 0; i < 40; i++) step(32'h0000_1000, 1'b0, "R4 flip");
    for (int i = 0; i < 40; i++) step(32'h0000_1000, 1'b1, "R4 flip back");
    for (int i = 0; i < 300; i++) step(32'h0000_2040, ((7'b1101100 >> (i % 7)) & 1) != 0, "R9 period");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pc = $urandom;
      step(pc, pc[5] ^ ($urandom_range(0, 7) == 0), "R2 scattered");
    end
    for (int i = 0; i < 8; i++) pcs[i] = {$urandom} & 32'h0003_fffc;
    for (int i = 0; i < 2000; i++) begin
      int p = $urandom_range(0, 7);
      step(pcs[p], ((i / (p + 1)) % 3) != 0, "R7 multi");
    end
    chk(m_alloc > 0, "R7", "allocations made", m_alloc, 1);
    for (int i = 0; i < 3000; i++) step(32'h0000_3c08, $urandom_range(0, 1) != 0, "R8 noise");
    chk(m_thr_peak >= 128, "R8", "throttle reached limit", m_thr_peak, 128);
    chk(m_denied > 0, "R8", "allocations denied", m_denied, 1);
    for (int i = 0; i < 200; i++) step(32'h0000_1000, 1'b1, "R8 recovery");
    @(negedge clk);
    upd_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule